// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Flow Controller

This block handles flow control for one decode pipeline stage serving a single hardware thread. Each cycle it takes up to `W` instruction tokens from fetch. Each token carries a sequence tag and a squashed flag. It passes up to `W` tokens per cycle on to rename. When rename asks for a stall, incoming tokens are parked in a skid buffer and a one-cycle block pulse goes back to fetch. When the stall lifts, parked tokens leave before any fresh token, in arrival order. Once the buffer runs dry, a one-cycle unblock pulse tells fetch to resume.

A flush from commit has priority over everything else. It drops the skid contents and the tokens arriving that cycle, and it places the stage in a one-cycle squashing state. Tokens that arrive already marked squashed still use their lane position, but they never show up as valid on the rename side. Forwarding is combinational from fetch lanes or skid head to rename lanes. The status, the skid occupancy and the pulses are derived from registered state.

Top module: `decode_skid_flow`

## Requirements
- R1: `stageStatus` encodes Idle=0, Blocked=1, Running=2, Unblocking=3, Squashing=4. Reset gives Idle. Idle moves to Running on the first cycle with `fetchCount` nonzero.
- R2: In Idle, Running or Squashing with no stall and no flush, rename lane i carries fetch lane i in the same cycle for every i below `fetchCount`. Lane 0 of `fetchSeq` and `renameSeq` is bits [SEQ_W-1:0].
- R3: A token whose squashed flag is set (bit i of `fetchSquashed` for lane i) takes its lane position but drives `renameValid[i]` low. This holds whether the token is forwarded directly or later drained from the skid buffer.
- R4: While `renameStall` is high and no flush is present, `renameValid` is all zero and the incoming tokens are appended to the skid buffer. The next status is Blocked. `fetchBlock` pulses when the current status is not already Blocked.
- R5: In the first cycle with the stall low while Blocked, the stage drains up to `W` of the oldest skid entries in that same cycle. Fresh tokens are appended behind them. The next status is Unblocking unless the buffer empties.
- R6: During Unblocking, output comes only from the skid buffer, up to `W` entries per cycle in first-in order. Fresh input is appended behind those entries.
- R7: In the cycle the skid buffer drains to empty with no fresh input, `fetchUnblock` pulses and the next status is Running.
- R8: `commitSquash` overrides stall and drain. It empties the skid buffer, drops that cycle's input and forwards nothing. The next status is Squashing. `fetchUnblock` pulses if the current status is Blocked or Unblocking.
- R9: Squashing lasts one cycle and then moves to Running unless a new stall or flush arrives.
- R10: `stageActive` is high when `fetchCount` is nonzero or the skid buffer holds entries.
- R11: `skidOverflow` is high in any cycle whose appended tokens exceed the free space left after that cycle's drain. The newest excess tokens are dropped.
- R12: `fetchBlock` and `fetchUnblock` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchCount | input | $clog2(W+1) | Number of tokens in lanes 0..fetchCount-1 this cycle |
| fetchSeq | input | W*SEQ_W | Sequence tags of the fetch lanes |
| fetchSquashed | input | W | Squashed flag per fetch lane |
| renameStall | input | 1 | Stall request from rename |
| commitSquash | input | 1 | Flush request from commit |
| renameValid | output | W | Valid per rename lane |
| renameSeq | output | W*SEQ_W | Sequence tags of the rename lanes |
| fetchBlock | output | 1 | One-cycle block notice to fetch |
| fetchUnblock | output | 1 | One-cycle unblock notice to fetch |
| stageStatus | output | 3 | Current stage status code |
| stageActive | output | 1 | Tokens present at input or in skid buffer |
| skidOverflow | output | 1 | Appended tokens exceed free skid space |

## Verification
The bench targets the cycle where a stall lifts. A design that waited a cycle before draining, or that let fresh input overtake parked tokens, would show tags out of order or a dead cycle. Squashed tokens are placed in both lanes, on the direct path and through the skid buffer. A design that compacted lanes or forwarded such tokens would show wrong valid bits. A flush is issued while Blocked and while Running, so a missing or spurious unblock pulse would be visible. The buffer is also filled exactly to depth and then past it, and the bench confirms that the overflow flag rises only on the excess cycle and that the retained tags still drain in order.

// File: rtl/decode_skid_pkg.sv
package decode_skid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_BLOCKED    = 3'd1,
    ST_RUNNING    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4
  } stage_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // empty the skid buffer
    logic drainSkid;  // forward from skid head
    logic pushFetch;  // append fetch lanes to skid
    logic passFetch;  // forward fetch lanes directly
  } skid_strobe_t;

endpackage

// File: rtl/decode_skid_ctrl.sv
module decode_skid_ctrl
  import decode_skid_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       renameStall,
  input  logic                       commitSquash,
  input  logic [$clog2(W+1)-1:0]     fetchCount,
  input  logic [$clog2(DEPTH+1)-1:0] skidCount,
  output skid_strobe_t               strobe,
  output stage_state_e               state,
  output logic                       fetchBlock,
  output logic                       fetchUnblock
);

  stage_state_e nextState;

  always_comb begin
    strobe       = '0;
    nextState    = state;
    fetchBlock   = 1'b0;
    fetchUnblock = 1'b0;
    if (commitSquash) begin
      strobe.clearAll = 1'b1;
      nextState       = ST_SQUASHING;
      fetchUnblock    = (state == ST_BLOCKED) || (state == ST_UNBLOCKING);
    end else if (renameStall) begin
      strobe.pushFetch = 1'b1;
      nextState        = ST_BLOCKED;
      fetchBlock       = (state != ST_BLOCKED);
    end else if ((state == ST_BLOCKED) || (state == ST_UNBLOCKING)) begin
      strobe.drainSkid = 1'b1;
      strobe.pushFetch = 1'b1;
      if ((int'(skidCount) <= W) && (fetchCount == '0)) begin
        nextState    = ST_RUNNING;
        fetchUnblock = 1'b1;
      end else begin
        nextState = ST_UNBLOCKING;
      end
    end else begin
      strobe.passFetch = 1'b1;
      if (state == ST_IDLE) nextState = (fetchCount != '0) ? ST_RUNNING : ST_IDLE;
      else                  nextState = ST_RUNNING;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/decode_skid_dp.sv
module decode_skid_dp
  import decode_skid_pkg::*;
#(
  parameter int W     = 2,
  parameter int SEQ_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  skid_strobe_t               strobe,
  input  logic [$clog2(W+1)-1:0]     fetchCount,
  input  logic [W*SEQ_W-1:0]         fetchSeq,
  input  logic [W-1:0]               fetchSquashed,
  output logic [W-1:0]               outValid,
  output logic [W*SEQ_W-1:0]         outSeq,
  output logic [$clog2(DEPTH+1)-1:0] skidCount,
  output logic                       overflow
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [SEQ_W-1:0] memSeq [DEPTH];
  logic [DEPTH-1:0] memSq;
  logic [PTR_W-1:0] head, tail;
  int popN, room, pushN;

  always_comb begin
    popN = 0;
    if (strobe.drainSkid) popN = (int'(skidCount) < W) ? int'(skidCount) : W;
    room  = DEPTH - (int'(skidCount) - popN);
    pushN = 0;
    if (strobe.pushFetch) pushN = (int'(fetchCount) < room) ? int'(fetchCount) : room;
    overflow = strobe.pushFetch && (int'(fetchCount) > room);
  end

  for (genvar lane = 0; lane < W; lane++) begin : g_lane
    logic [PTR_W-1:0] rdIdx;
    logic             laneValid;
    logic [SEQ_W-1:0] laneSeq;
    assign rdIdx = head + PTR_W'(lane);
    always_comb begin
      laneValid = 1'b0;
      laneSeq   = '0;
      if (strobe.drainSkid) begin
        laneValid = (lane < popN) && !memSq[rdIdx];
        laneSeq   = memSeq[rdIdx];
      end else if (strobe.passFetch) begin
        laneValid = (lane < int'(fetchCount)) && !fetchSquashed[lane];
        laneSeq   = fetchSeq[lane*SEQ_W +: SEQ_W];
      end
    end
    assign outValid[lane]                = laneValid;
    assign outSeq[lane*SEQ_W +: SEQ_W]   = laneSeq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      skidCount <= '0;
    end else if (strobe.clearAll) begin
      head      <= '0;
      tail      <= '0;
      skidCount <= '0;
    end else begin
      head      <= head + PTR_W'(popN);
      tail      <= tail + PTR_W'(pushN);
      skidCount <= CNT_W'(int'(skidCount) - popN + pushN);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (i < pushN) begin
        memSeq[tail + PTR_W'(i)] <= fetchSeq[i*SEQ_W +: SEQ_W];
        memSq[tail + PTR_W'(i)]  <= fetchSquashed[i];
      end
    end
  end

endmodule

// File: rtl/decode_skid_flow.sv
module decode_skid_flow
  import decode_skid_pkg::*;
#(
  parameter int W     = 2,
  parameter int SEQ_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(W+1)-1:0] fetchCount,
  input  logic [W*SEQ_W-1:0]     fetchSeq,
  input  logic [W-1:0]           fetchSquashed,
  input  logic                   renameStall,
  input  logic                   commitSquash,
  output logic [W-1:0]           renameValid,
  output logic [W*SEQ_W-1:0]     renameSeq,
  output logic                   fetchBlock,
  output logic                   fetchUnblock,
  output logic [2:0]             stageStatus,
  output logic                   stageActive,
  output logic                   skidOverflow
);

  localparam int CNT_W = $clog2(DEPTH+1);

  skid_strobe_t     strobe;
  stage_state_e     state;
  logic [CNT_W-1:0] skidCount;

  decode_skid_ctrl #(.W(W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .renameStall(renameStall), .commitSquash(commitSquash),
    .fetchCount(fetchCount), .skidCount(skidCount), .strobe(strobe), .state(state),
    .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock)
  );

  decode_skid_dp #(.W(W), .SEQ_W(SEQ_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchCount(fetchCount),
    .fetchSeq(fetchSeq), .fetchSquashed(fetchSquashed), .outValid(renameValid),
    .outSeq(renameSeq), .skidCount(skidCount), .overflow(skidOverflow)
  );

  assign stageStatus = state;
  assign stageActive = (fetchCount != '0) || (skidCount != '0);

endmodule

// File: rtl/decode_skid_flow_chk.sv
module decode_skid_flow_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         renameStall,
  input logic         commitSquash,
  input logic [W-1:0] renameValid,
  input logic         fetchBlock,
  input logic         fetchUnblock,
  input logic [2:0]   stageStatus,
  input logic         skidOverflow
);

  // R1
  status_range_chk: assert property (@(posedge clk) disable iff (!rstN) stageStatus <= 3'd4);
  // R4
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) renameStall |-> renameValid == '0);
  // R4
  stall_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (renameStall && !commitSquash) |=> stageStatus == 3'd1);
  // R7
  unblock_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchUnblock && !commitSquash) |=> stageStatus == 3'd2);
  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) commitSquash |-> renameValid == '0);
  // R8
  squash_state_chk: assert property (@(posedge clk) disable iff (!rstN) commitSquash |=> stageStatus == 3'd4);
  // R9
  squash_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stageStatus == 3'd4 && !commitSquash && !renameStall) |=> stageStatus == 3'd2);
  // R11
  overflow_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    skidOverflow |-> (renameStall || stageStatus == 3'd1 || stageStatus == 3'd3));
  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(fetchBlock && fetchUnblock));
  // R12
  block_single_chk: assert property (@(posedge clk) disable iff (!rstN) fetchBlock |=> !fetchBlock);
  // R12
  unblock_single_chk: assert property (@(posedge clk) disable iff (!rstN) fetchUnblock |=> !fetchUnblock);

endmodule

bind decode_skid_flow decode_skid_flow_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .renameStall(renameStall), .commitSquash(commitSquash),
  .renameValid(renameValid), .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock),
  .stageStatus(stageStatus), .skidOverflow(skidOverflow)
);

// File: tb/decode_skid_flow_tb_top.sv
`timescale 1ns/1ps
module decode_skid_flow_tb_top;

  localparam int W     = 2;
  localparam int SEQ_W = 8;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       fetchCount = '0;
  logic [15:0]      fetchSeq = '0;
  logic [1:0]       fetchSquashed = '0;
  logic             renameStall = 1'b0;
  logic             commitSquash = 1'b0;
  logic [1:0]       renameValid;
  logic [15:0]      renameSeq;
  logic             fetchBlock, fetchUnblock, stageActive, skidOverflow;
  logic [2:0]       stageStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  decode_skid_flow #(.W(W), .SEQ_W(SEQ_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .fetchCount(fetchCount), .fetchSeq(fetchSeq),
    .fetchSquashed(fetchSquashed), .renameStall(renameStall), .commitSquash(commitSquash),
    .renameValid(renameValid), .renameSeq(renameSeq), .fetchBlock(fetchBlock),
    .fetchUnblock(fetchUnblock), .stageStatus(stageStatus), .stageActive(stageActive),
    .skidOverflow(skidOverflow)
  );

  typedef struct packed {
    logic       stall;
    logic       squash;
    logic [1:0] cnt;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [1:0] sq;
    logic [1:0] eVal;
    logic [7:0] e0;
    logic [7:0] e1;
    logic       eBlk;
    logic       eUnb;
    logic [2:0] eStat;
    logic       eAct;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b0,3'd0,1'b0},
    '{1'b0,1'b0,2'd2,8'd1, 8'd2, 2'b00,2'b11,8'd1, 8'd2, 1'b0,1'b0,3'd0,1'b1},
    '{1'b0,1'b0,2'd2,8'd3, 8'd4, 2'b00,2'b11,8'd3, 8'd4, 1'b0,1'b0,3'd2,1'b1},
    '{1'b1,1'b0,2'd2,8'd5, 8'd6, 2'b00,2'b00,8'd0, 8'd0, 1'b1,1'b0,3'd2,1'b1},
    '{1'b1,1'b0,2'd1,8'd7, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b0,3'd1,1'b1},
    '{1'b0,1'b0,2'd2,8'd8, 8'd9, 2'b00,2'b11,8'd5, 8'd6, 1'b0,1'b0,3'd1,1'b1},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b11,8'd7, 8'd8, 1'b0,1'b0,3'd3,1'b1},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b01,8'd9, 8'd0, 1'b0,1'b1,3'd3,1'b1},
    '{1'b0,1'b0,2'd2,8'd10,8'd11,2'b10,2'b01,8'd10,8'd0, 1'b0,1'b0,3'd2,1'b1},
    '{1'b1,1'b0,2'd2,8'd12,8'd13,2'b01,2'b00,8'd0, 8'd0, 1'b1,1'b0,3'd2,1'b1},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b10,8'd0, 8'd13,1'b0,1'b1,3'd1,1'b1},
    '{1'b1,1'b0,2'd1,8'd14,8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b1,1'b0,3'd2,1'b1},
    '{1'b0,1'b1,2'd2,8'd15,8'd16,2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b1,3'd1,1'b1},
    '{1'b0,1'b0,2'd2,8'd17,8'd18,2'b00,2'b11,8'd17,8'd18,1'b0,1'b0,3'd4,1'b1},
    '{1'b0,1'b0,2'd1,8'd19,8'd0, 2'b00,2'b01,8'd19,8'd0, 1'b0,1'b0,3'd2,1'b1},
    '{1'b1,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b1,1'b0,3'd2,1'b0},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b1,3'd1,1'b0},
    '{1'b0,1'b1,2'd1,8'd20,8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b0,3'd2,1'b1},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b0,3'd4,1'b0},
    '{1'b0,1'b0,2'd0,8'd0, 8'd0, 2'b00,2'b00,8'd0, 8'd0, 1'b0,1'b0,3'd2,1'b0}
  };

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic drive(input bit stall, input bit squash, input logic [1:0] cnt,
                       input logic [7:0] s0, input logic [7:0] s1, input logic [1:0] sq);
    @(negedge clk);
    renameStall   = stall;
    commitSquash  = squash;
    fetchCount    = cnt;
    fetchSeq      = {s1, s0};
    fetchSquashed = sq;
    #1;
  endtask

  task automatic checkLanes(input string req, input logic [1:0] eVal, input logic [7:0] e0,
                            input logic [7:0] e1);
    check(renameValid == eVal, req, renameValid, eVal);
    if (eVal[0]) check(renameSeq[7:0] == e0, req, renameSeq[7:0], e0);
    if (eVal[1]) check(renameSeq[15:8] == e1, req, renameSeq[15:8], e1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state, R10 inactive
    check(stageStatus == 3'd0, "R1 reset status", stageStatus, 0);
    check(renameValid == 2'b00, "R2 reset lanes", renameValid, 0);
    check(!fetchBlock && !fetchUnblock, "R12 reset pulses", {fetchBlock, fetchUnblock}, 0);
    check(!stageActive, "R10 reset active", stageActive, 0);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int r = 0; r < 20; r++) begin
      drive(VEC[r].stall, VEC[r].squash, VEC[r].cnt, VEC[r].s0, VEC[r].s1, VEC[r].sq);
      check(stageStatus == VEC[r].eStat, "R1 status", stageStatus, VEC[r].eStat);
      checkLanes("R2 R3 lanes", VEC[r].eVal, VEC[r].e0, VEC[r].e1);
      check(fetchBlock == VEC[r].eBlk, "R4 block pulse", fetchBlock, VEC[r].eBlk);
      check(fetchUnblock == VEC[r].eUnb, "R7 R8 unblock pulse", fetchUnblock, VEC[r].eUnb);
      check(stageActive == VEC[r].eAct, "R10 active", stageActive, VEC[r].eAct);
    end

    // R11: fill to depth under stall, then exceed it
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 1'b0, 2'd2, 8'(30 + 2*k), 8'(31 + 2*k), 2'b00);
      check(skidOverflow == (k == 4), "R11 overflow", skidOverflow, (k == 4));
      check(renameValid == 2'b00, "R4 stalled lanes", renameValid, 0);
    end
    // R5 R6: drain retains first-in order; R7 unblock on the last drain
    for (int j = 0; j < 4; j++) begin
      drive(1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 2'b00);
      checkLanes("R6 drain order", 2'b11, 8'(30 + 2*j), 8'(31 + 2*j));
      check(fetchUnblock == (j == 3), "R7 unblock at empty", fetchUnblock, (j == 3));
      check(stageStatus == ((j == 0) ? 3'd1 : 3'd3), "R5 status while draining",
            stageStatus, (j == 0) ? 1 : 3);
    end
    drive(1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 2'b00);
    check(stageStatus == 3'd2, "R7 running after drain", stageStatus, 2);
    check(!stageActive, "R10 empty after drain", stageActive, 0);

    // R8: flush while Unblocking
    drive(1'b1, 1'b0, 2'd2, 8'd40, 8'd41, 2'b00);
    drive(1'b1, 1'b0, 2'd2, 8'd42, 8'd43, 2'b00);
    drive(1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 2'b00);
    checkLanes("R5 first drain", 2'b11, 8'd40, 8'd41);
    drive(1'b0, 1'b1, 2'd1, 8'd44, 8'd0, 2'b00);
    check(stageStatus == 3'd3, "R8 pre-flush status", stageStatus, 3);
    check(fetchUnblock, "R8 unblock on flush", fetchUnblock, 1);
    check(renameValid == 2'b00, "R8 flush lanes", renameValid, 0);
    drive(1'b0, 1'b0, 2'd0, 8'd0, 8'd0, 2'b00);
    check(stageStatus == 3'd4, "R9 squashing", stageStatus, 4);
    check(!stageActive, "R8 skid cleared", stageActive, 0);
    drive(1'b0, 1'b0, 2'd1, 8'd45, 8'd0, 2'b00);
    check(stageStatus == 3'd2, "R9 back to running", stageStatus, 2);
    checkLanes("R2 after flush", 2'b01, 8'd45, 8'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule